// File: doc/BRIEF.md
# Firmware Memory Command Register

This block decodes writes to a single write-only command register and uses them to run an on-chip firmware memory. When the arm code is written, a separate load register becomes live. Each byte written to the load register then goes into the memory at the next address in sequence. When the test code is written, the block halts navigation and computes a 16-bit CRC over the whole memory, one byte per clock.

The result does not appear the moment the CRC finishes. The block first waits a fixed delay, measured in clock cycles from a clock-frequency parameter and a millisecond count. It then waits for the next frame-start pulse. On that pulse it latches the result and releases navigation. The lower and upper bytes of the result are read at two separate addresses.

Any other command value disarms the load path and starts no test. The register file is reached through a plain write strobe and a read strobe. Read data is registered and arrives one cycle after the read strobe.

Top module: `fw_cmd_ctrl`

## Requirements
- R1: After reset, `nav_halt` is 0, both result addresses read 0x00, and the load path is disarmed.
- R2: Writing 0x18 to the command address arms loading and returns the load pointer to memory address 0. Each later load write stores its byte at the pointer and then advances the pointer by one.
- R3: A load write while the command register holds any value other than 0x18 leaves the memory unchanged.
- R4: Writing a command value other than 0x18 or 0xA1 disarms loading and leaves `nav_halt` at 0.
- R5: Writing 0xA1 while idle sets `nav_halt` on the next cycle. While `nav_halt` is 1, both result addresses read 0x00.
- R6: The result is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, taken MSB-first over every memory byte in ascending address order, with no final XOR.
- R7: `nav_halt` falls, and the result is latched, on the first clock edge where `frame_start` is 1 at least DELAY cycles after the edge that captured the 0xA1 write. DELAY is (CLK_HZ/1000)*DELAY_MS. A pulse at DELAY-1 cycles or earlier is ignored.
- R8: The lower result byte is read at RES_LO_ADDR and the upper byte at RES_HI_ADDR. Read data appears on the cycle after `rd_en`. It is 0x00 when there is no read, and also for the write-only command address.
- R9: Command writes are ignored while `nav_halt` is 1.
- R10: After the last memory address, the load pointer wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after `rd_en` |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| nav_halt | output | 1 | High from the test command until the result is latched |

## Verification
The hardest condition to reach from the ports is the exact edge of the acceptance window. The test requires a frame pulse exactly one cycle before the delay expires, held into the very next cycle where it must be taken. The bench counts clock edges from the edge that captured the test command and places `frame_start` at those two edges. It shrinks CLK_HZ so that the window stays short.

Command writes made during a test leave no direct trace, so the bench exposes them indirectly. It writes the arm code mid-test, then loads bytes after the test ends and runs a second test. A dropped command leaves the CRC unchanged; a command that slipped through would have moved it.

// File: rtl/fw_cmd_pkg.sv
package fw_cmd_pkg;

  localparam logic [7:0]  CMD_ARM   = 8'h18;
  localparam logic [7:0]  CMD_TEST  = 8'hA1;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  // Fold one byte into a CRC-16, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fw_cmd_mem.sv
module fw_cmd_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fw_cmd_crc.sv
module fw_cmd_crc
  import fw_cmd_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic [15:0]   crc_out,
  output logic          crc_done
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic          run_q;
  logic          vld_q;
  logic [CW-1:0] cnt_q;
  logic          issue;

  assign issue     = run_q && (cnt_q < LAST);
  assign mem_raddr = cnt_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      vld_q    <= 1'b0;
      cnt_q    <= '0;
      crc_out  <= CRC_SEED;
      crc_done <= 1'b0;
    end else if (start) begin
      run_q    <= 1'b1;
      vld_q    <= 1'b0;
      cnt_q    <= '0;
      crc_out  <= CRC_SEED;
      crc_done <= 1'b0;
    end else begin
      vld_q <= issue;
      if (issue) cnt_q <= cnt_q + 1'b1;
      if (vld_q) crc_out <= crc16_step(crc_out, mem_rdata);
      if (run_q && !issue && !vld_q) begin
        run_q    <= 1'b0;
        crc_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fw_cmd_wait.sv
module fw_cmd_wait #(
  parameter int DELAY_CYC = 1400000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic elapsed
);

  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  // After the start edge W, at edge W+k the count reads k-1 (saturating).
  assign elapsed = (cnt_q >= LIM);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= LIM;
    else if (start)       cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/fw_cmd_ctrl.sv
module fw_cmd_ctrl
  import fw_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_DEPTH = 1024,
  parameter int CLK_HZ    = 200000000,
  parameter int DELAY_MS  = 7,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h14,
  parameter logic [ADDR_W-1:0] LOAD_ADDR   = 'h16,
  parameter logic [ADDR_W-1:0] RES_LO_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] RES_HI_ADDR = 'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              frame_start,
  output logic              nav_halt
);

  localparam int AW        = $clog2(MEM_DEPTH);
  localparam int DELAY_CYC = (CLK_HZ / 1000) * DELAY_MS;
  localparam logic [AW-1:0] PTR_LAST = AW'(MEM_DEPTH - 1);

  logic [7:0]    cmd_q;
  logic          busy_q;
  logic [15:0]   res_q;
  logic [AW-1:0] ld_ptr_q;

  logic          cmd_wr, ld_wr, test_start, finish;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata;
  logic [15:0]   crc_val;
  logic          crc_done, elapsed;

  assign cmd_wr     = wr_en && (wr_addr == CMD_ADDR) && !busy_q;
  assign ld_wr      = wr_en && (wr_addr == LOAD_ADDR) && (cmd_q == CMD_ARM) && !busy_q;
  assign test_start = cmd_wr && (wr_data == CMD_TEST);
  assign finish     = busy_q && elapsed && crc_done && frame_start;
  assign nav_halt   = busy_q;

  fw_cmd_mem #(.DEPTH(MEM_DEPTH), .AW(AW)) mem_i (
    .clk   (clk),
    .we    (ld_wr),
    .waddr (ld_ptr_q),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  fw_cmd_crc #(.DEPTH(MEM_DEPTH), .AW(AW)) crc_i (
    .clk       (clk),
    .rst       (rst),
    .start     (test_start),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .crc_out   (crc_val),
    .crc_done  (crc_done)
  );

  fw_cmd_wait #(.DELAY_CYC(DELAY_CYC)) wait_i (
    .clk     (clk),
    .rst     (rst),
    .start   (test_start),
    .elapsed (elapsed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      res_q    <= '0;
      ld_ptr_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q <= wr_data;
        if (wr_data == CMD_ARM) ld_ptr_q <= '0;
      end else if (ld_wr) begin
        ld_ptr_q <= (ld_ptr_q == PTR_LAST) ? '0 : ld_ptr_q + 1'b1;
      end
      if (test_start) begin
        busy_q <= 1'b1;
        res_q  <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        res_q  <= crc_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_en) begin
        if (rd_addr == RES_LO_ADDR)      rd_data <= res_q[7:0];
        else if (rd_addr == RES_HI_ADDR) rd_data <= res_q[15:8];
      end
    end
  end

endmodule

// File: rtl/fw_cmd_ctrl_chk.sv
module fw_cmd_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int DELAY_CYC = 1400000,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h14,
  parameter logic [ADDR_W-1:0] RES_LO_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] RES_HI_ADDR = 'h1D
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              frame_start,
  input logic              nav_halt
);

  logic [31:0] halt_cyc;

  always_ff @(posedge clk) begin
    if (rst || !nav_halt) halt_cyc <= '0;
    else                  halt_cyc <= halt_cyc + 1;
  end

  assert_test_start_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CMD_ADDR && wr_data == 8'hA1 && !nav_halt) |=> nav_halt);

  assert_other_no_test_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CMD_ADDR && wr_data != 8'hA1 && !nav_halt) |=> !nav_halt);

  assert_hold_without_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (nav_halt && !frame_start) |=> nav_halt);

  assert_min_delay_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(nav_halt) |-> (halt_cyc >= 32'(DELAY_CYC)));

  assert_zero_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (nav_halt && rd_en && (rd_addr == RES_LO_ADDR || rd_addr == RES_HI_ADDR)) |=> (rd_data == 8'h00));

  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 8'h00));

endmodule

bind fw_cmd_ctrl fw_cmd_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .DELAY_CYC   (DELAY_CYC),
  .CMD_ADDR    (CMD_ADDR),
  .RES_LO_ADDR (RES_LO_ADDR),
  .RES_HI_ADDR (RES_HI_ADDR)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .frame_start (frame_start),
  .nav_halt    (nav_halt)
);

// File: tb/fw_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module fw_cmd_ctrl_tb_top;

  localparam int DEPTH  = 16;
  localparam int CLK_HZ = 200000;
  localparam int DELAY  = (CLK_HZ / 1000) * 7;
  localparam logic [7:0] A_CMD = 8'h14, A_LOAD = 8'h16, A_LO = 8'h1C, A_HI = 8'h1D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, frame_start = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic nav_halt;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] model [DEPTH];
  int ptr = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fw_cmd_ctrl #(.MEM_DEPTH(DEPTH), .CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start), .nav_halt(nav_halt)
  );

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < DEPTH; i++) begin
      c = c ^ {model[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: push expected byte, issue read.
  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] d);
    wr(A_LOAD, d);
    model[ptr] = d;
    ptr = (ptr + 1) % DEPTH;
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // Monitor: compare registered read data against the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8: unexpected read result 0x%0h expected none", rd_data);
        end else begin
          check({8'h00, rd_data}, {8'h00, exp_q.pop_front()}, tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    logic [15:0] c1, c3;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check({15'd0, nav_halt}, 16'd0, "R1 nav_halt after reset");
    rd_exp(A_LO, 8'h00, "R1 result low after reset");
    rd_exp(A_HI, 8'h00, "R1 result high after reset");
    rd_exp(A_CMD, 8'h00, "R8 command address reads zero");

    // R3: loads while disarmed are dropped (memory model unchanged)
    for (int i = 0; i < 4; i++) wr(A_LOAD, 8'hEE);

    // R2 / R10: arm, fill, wrap
    wr(A_CMD, 8'h18); ptr = 0;
    for (int i = 0; i < DEPTH; i++) load(8'(i * 7 + 3));
    load(8'h55); load(8'hAA);

    // R4: other code disarms, no test
    wr(A_CMD, 8'h33);
    check({15'd0, nav_halt}, 16'd0, "R4 no test on other code");
    wr(A_LOAD, 8'h99);

    // Test 1: exact window boundary
    wr(A_CMD, 8'hA1); w = cyc;
    c1 = ref_crc();
    check({15'd0, nav_halt}, 16'd1, "R5 halt after test code");
    rd_exp(A_HI, 8'h00, "R5 result zero while busy");
    wr(A_CMD, 8'h18);                 // R9: must be ignored
    pulse();
    check({15'd0, nav_halt}, 16'd1, "R7 early frame ignored");
    do @(negedge clk); while (cyc < w + DELAY - 2);
    frame_start = 1'b1;
    @(negedge clk);
    check({15'd0, nav_halt}, 16'd1, "R7 frame at DELAY-1 ignored");
    @(negedge clk);
    frame_start = 1'b0;
    check({15'd0, nav_halt}, 16'd0, "R7 frame at DELAY accepted");
    rd_exp(A_LO, c1[7:0],  "R6 R8 result low test1");
    rd_exp(A_HI, c1[15:8], "R6 R8 result high test1");

    // Test 2: R9 - command still 0xA1, loads must be dropped
    for (int i = 0; i < 3; i++) wr(A_LOAD, 8'h77);
    wr(A_CMD, 8'hA1);
    check({15'd0, nav_halt}, 16'd1, "R5 halt test2");
    repeat (DELAY + 100) @(negedge clk);
    check({15'd0, nav_halt}, 16'd1, "R7 held until frame");
    pulse();
    check({15'd0, nav_halt}, 16'd0, "R7 release test2");
    rd_exp(A_LO, c1[7:0],  "R9 R3 result low unchanged");
    rd_exp(A_HI, c1[15:8], "R9 R3 result high unchanged");

    // Test 3: R2 re-arm returns pointer to 0
    wr(A_CMD, 8'h18); ptr = 0;
    load(8'hC0); load(8'hC1); load(8'hC2);
    c3 = ref_crc();
    wr(A_CMD, 8'hA1);
    rd_exp(A_LO, 8'h00, "R5 result low zero while busy");
    repeat (DELAY + 10) @(negedge clk);
    pulse();
    check({15'd0, nav_halt}, 16'd0, "R7 release test3");
    rd_exp(A_LO, c3[7:0],  "R2 R6 result low test3");
    rd_exp(A_HI, c3[15:8], "R2 R6 result high test3");

    repeat (4) @(negedge clk);
    check(16'(exp_q.size()), 16'd0, "R8 all reads answered");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule